// File: doc/BRIEF.md
# Framed Serial Transmitter with Optional Synchronous Clock

This block turns parallel bytes into asynchronous serial frames on a single data line. Each frame has one low start bit, eight data bits sent least significant bit first, and a high stop interval. The length of the stop interval is chosen per frame in half-bit steps. Bit timing comes from an external enable pulse that arrives sixteen times per bit period. The block does not generate that pulse itself.

When its line-break mode is on, the block can also send a break: thirteen bit periods of continuous low, then one bit period of high before the next frame may start. It can drive a clock output alongside the data so that a synchronous receiver can capture each data bit. The resting level of that clock and which of its two edges in a bit carries the capture are both selectable. Bytes arrive through a valid/ready handshake. A busy flag stays high for as long as a frame or break is in progress.

Top module: `sync_uart_tx`

## Requirements
- R1: After reset the data line is high, busy is low, ready is high and the clock output sits at the level given by the polarity input.
- R2: An accepted byte produces a start bit held low for 16 ticks, followed by 8 data bits of 16 ticks each, bit 0 first.
- R3: The stop interval is high and lasts 16 ticks for stop code 2'b00, 8 ticks for 2'b01, 32 ticks for 2'b10 and 24 ticks for 2'b11. The code is captured when the byte is accepted. Busy falls in the cycle the last stop tick is consumed.
- R4: A byte is taken only on a clock edge where valid and ready are both high. Ready stays low for the whole of a frame or break.
- R5: With line-break mode on, a break request while idle drives the data line low for 13×16 ticks and then high for 16 ticks. Busy covers both intervals.
- R6: A break request has no effect when line-break mode is off, and also when it arrives while a frame is in progress. Busy and the data line are unchanged in both cases.
- R7: With the clock enable low, the clock output holds the polarity level for the entire frame.
- R8: Outside the data bits (idle, start, stop, break), the clock output equals the polarity input: 0 rests low, 1 rests high.
- R9: With the clock enabled, each data bit carries one clock pulse. With phase 0 the clock is at its active (non-rest) level during ticks 8..15 of the bit, so the first transition, at mid-bit, is the capture edge. With phase 1 it is active during ticks 0..7, so the second transition, at mid-bit, is the capture edge.
- R10: If a valid byte and a break request (line-break mode on) arrive in the same cycle while idle, the break wins. Ready is low in that cycle and the byte is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, sixteen per bit period |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte on tx_data_i is valid |
| tx_ready_o | output | 1 | Block can take a byte this cycle |
| brk_req_i | input | 1 | Break request strobe |
| stop_sel_i | input | 2 | Stop length code |
| lin_en_i | input | 1 | Line-break mode enable |
| sclk_en_i | input | 1 | Synchronous clock output enable |
| sclk_pol_i | input | 1 | Clock rest level |
| sclk_pha_i | input | 1 | Clock phase select |
| txd_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Synchronous clock output |
| busy_o | output | 1 | Frame or break in progress |

## Verification
A tick counter that slips or a limit chosen wrongly shows up at once as a wrong busy duration, and the sampled bit values come out shifted. The bench measures the busy duration of every frame and every break to within one tick, so a slip is caught by the end of the affected frame. A wrong shift position or bit index gives a mismatching decoded byte, which is sampled at the centre of each bit. A fault in the phase or polarity logic shows within the first data bit, because the clock level is sampled at the quarter and three-quarter points of every bit.

// File: rtl/sutx_pkg.sv
// Shared types for the framed serial transmitter.
// Assumes the oversampling factor is even so a half bit is a whole tick count.
package sutx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_BREAK,
        ST_GAP
    } sutx_state_e;

    // Stop interval length in ticks for a stop code and ticks-per-bit value.
    function automatic int unsigned stop_ticks(input logic [1:0] code, input int unsigned os);
        case (code)
            2'b00:   return os;
            2'b01:   return os / 2;
            2'b10:   return 2 * os;
            default: return os + os / 2;
        endcase
    endfunction

endpackage

// File: rtl/sutx_bit_timer.sv
// Tick counter for the current line interval. Counts tick pulses up to
// limit_i and flags the pulse that completes the interval, then wraps to 0.
// Assumes limit_i is nonzero and only changes when the count is 0.
module sutx_bit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    assign done_o = tick_i && !clear_i && (cnt_q == limit_i - 1'b1);
    assign cnt_o  = cnt_q;

    // Advance on each tick, wrap when the interval ends, hold at 0 while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (done_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < limit_i); // R3

endmodule

// File: rtl/sutx_shifter.sv
// Data shift register with a bit index. Loads a byte and presents bit 0,
// then shifts right on request. last_o marks the final data bit.
// Assumes shift_i is never raised while last_o is high.
module sutx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              last_o
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    assign bit_o  = sh_q[0];
    assign last_o = (idx_q == IDX_W'(DATA_W - 1));

    // Capture a new byte or move the next bit into position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sh_q  <= data_i;
            idx_q <= '0;
        end else if (shift_i) begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
        end
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) shift_i |-> !last_o); // R2

endmodule

// File: rtl/sutx_sclk_gen.sv
// Synchronous clock output. Gives one pulse per data bit; its half within
// the bit is chosen by phase, and its rest level by polarity.
// Assumes the tick count restarts at 0 at every data bit boundary.
module sutx_sclk_gen #(
    parameter int CNT_W      = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic             in_data_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             en_i,
    input  logic             pol_i,
    input  logic             pha_i,
    output logic             sclk_o
);

    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(OVERSAMPLE / 2);

    logic second_half;
    logic active;

    // Decide whether the clock sits at its active level in this part of the bit.
    always_comb begin
        second_half = (cnt_i >= HALF_C);
        active      = en_i && in_data_i && (pha_i ? !second_half : second_half);
        sclk_o      = pol_i ^ active;
    end

endmodule

// File: rtl/sync_uart_tx.sv
// Framed serial transmitter top. Sequences start, data, stop, break and
// post-break gap intervals, and drives the data line, clock output,
// ready and busy. Assumes tick_i is a single-cycle pulse.
module sync_uart_tx #(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int BREAK_BITS  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    input  logic              brk_req_i,
    input  logic [1:0]        stop_sel_i,
    input  logic              lin_en_i,
    input  logic              sclk_en_i,
    input  logic              sclk_pol_i,
    input  logic              sclk_pha_i,
    output logic              txd_o,
    output logic              sclk_o,
    output logic              busy_o
);

    import sutx_pkg::*;

    localparam int MAX_TICKS = ((BREAK_BITS > 2) ? BREAK_BITS : 2) * OVERSAMPLE;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] LIM_BIT = CNT_W'(OVERSAMPLE);
    localparam logic [CNT_W-1:0] LIM_BRK = CNT_W'(BREAK_BITS * OVERSAMPLE);

    sutx_state_e      state_q, state_d;
    logic [1:0]       stop_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;
    logic             done;
    logic             brk_go;
    logic             accept;
    logic             load;
    logic             shift;
    logic             data_bit;
    logic             last_bit;

    assign brk_go     = (state_q == ST_IDLE) && brk_req_i && lin_en_i;
    assign tx_ready_o = (state_q == ST_IDLE) && !(brk_req_i && lin_en_i);
    assign accept     = tx_valid_i && tx_ready_o;
    assign load       = accept;
    assign shift      = (state_q == ST_DATA) && done && !last_bit;
    assign busy_o     = (state_q != ST_IDLE);

    // Pick the tick length of the interval in progress.
    always_comb begin
        case (state_q)
            ST_STOP:  limit = CNT_W'(stop_ticks(stop_q, OVERSAMPLE));
            ST_BREAK: limit = LIM_BRK;
            default:  limit = LIM_BIT;
        endcase
    end

    // Next-state sequencing of the line intervals.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (brk_go) state_d = ST_BREAK;
                      else if (accept) state_d = ST_START;
            ST_START: if (done) state_d = ST_DATA;
            ST_DATA:  if (done && last_bit) state_d = ST_STOP;
            ST_STOP:  if (done) state_d = ST_IDLE;
            ST_BREAK: if (done) state_d = ST_GAP;
            ST_GAP:   if (done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and stop code capture at byte acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stop_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            if (accept) stop_q <= stop_sel_i;
        end
    end

    // Data line level per interval.
    always_comb begin
        case (state_q)
            ST_START: txd_o = 1'b0;
            ST_DATA:  txd_o = data_bit;
            ST_BREAK: txd_o = 1'b0;
            default:  txd_o = 1'b1;
        endcase
    end

    sutx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .clear_i (state_q == ST_IDLE),
        .limit_i (limit),
        .cnt_o   (cnt),
        .done_o  (done)
    );

    sutx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .data_i  (tx_data_i),
        .shift_i (shift),
        .bit_o   (data_bit),
        .last_o  (last_bit)
    );

    sutx_sclk_gen #(.CNT_W(CNT_W), .OVERSAMPLE(OVERSAMPLE)) u_sclk (
        .in_data_i (state_q == ST_DATA),
        .cnt_i     (cnt),
        .en_i      (sclk_en_i),
        .pol_i     (sclk_pol_i),
        .pha_i     (sclk_pha_i),
        .sclk_o    (sclk_o)
    );

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n) accept |=> (busy_o && !txd_o)); // R4
    AST_BREAK_GOES_LOW: assert property (@(posedge clk) disable iff (!rst_n) brk_go |=> (!txd_o && !tx_ready_o)); // R5
    AST_BREAK_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && brk_req_i && !lin_en_i && !tx_valid_i) |=> !busy_o); // R6
    AST_SCLK_RESTS: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> (sclk_o == sclk_pol_i)); // R8
    AST_BREAK_BEATS_BYTE: assert property (@(posedge clk) disable iff (!rst_n) brk_go |-> !tx_ready_o); // R10

endmodule

// File: tb/tb_sync_uart_tx.sv
module tb_sync_uart_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] data = 8'h00;
    logic       valid = 1'b0;
    logic       ready;
    logic       brk = 1'b0;
    logic [1:0] stop_sel = 2'b00;
    logic       lin_en = 1'b0;
    logic       sen = 1'b0;
    logic       pol = 1'b0;
    logic       pha = 1'b0;
    logic       txd, sclk, busy;

    int tests = 0;
    int fails = 0;

    sync_uart_tx dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .tx_data_i(data), .tx_valid_i(valid), .tx_ready_o(ready),
        .brk_req_i(brk), .stop_sel_i(stop_sel), .lin_en_i(lin_en),
        .sclk_en_i(sen), .sclk_pol_i(pol), .sclk_pha_i(pha),
        .txd_o(txd), .sclk_o(sclk), .busy_o(busy)
    );

    initial forever #10 clk = ~clk;

    // One tick every four clocks, driven at the falling edge.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph   = (ph + 1) % 4;
            tick = (ph == 3);
        end
    end

    function automatic int exp_stop_ticks(input logic [1:0] c);
        case (c)
            2'b00: return 16;
            2'b01: return 8;
            2'b10: return 32;
            default: return 24;
        endcase
    endfunction

    // Clock level expected in a data bit: first or second half.
    function automatic logic exp_sclk(input logic p, input logic e, input logic ph, input bit second);
        return p ^ (e && (ph ? !second : second));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] d, input logic [1:0] sc,
                             input logic e, input logic p, input logic ph, input bit brk_mid);
        logic [7:0] got = 8'h00;
        int bz = 0;
        int m = 0;
        int st = exp_stop_ticks(sc);
        int n = 144 + st;
        int sclk_bad = 0;
        int rdy_bad = 0;
        logic start_lvl = 1'b1;
        logic start_clk = 1'b0;
        logic stop_lvl = 1'b0;
        wait_idle();
        @(negedge clk);
        data = d; stop_sel = sc; sen = e; pol = p; pha = ph; lin_en = brk_mid; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        stop_sel = ~sc;
        while (busy) begin
            brk = brk_mid && (m == 200);
            #1;
            if (ready) rdy_bad++;
            if (m == 36) begin start_lvl = txd; start_clk = sclk; end
            for (int k = 0; k < 8; k++) begin
                if (m == 64 * (k + 1) + 36) got[k] = txd;
                if (m == 64 * (k + 1) + 20 && sclk !== exp_sclk(p, e, ph, 1'b0)) sclk_bad++;
                if (m == 64 * (k + 1) + 52 && sclk !== exp_sclk(p, e, ph, 1'b1)) sclk_bad++;
            end
            if (m == 576 + 2 * st) stop_lvl = txd;
            bz++; m++;
            @(negedge clk);
        end
        brk = 1'b0;
        check(start_lvl == 1'b0, "R2 start bit level", start_lvl, 0);
        check(got == d, "R2 data bits lsb first", got, d);
        check(stop_lvl == 1'b1, "R3 stop level", stop_lvl, 1);
        check(bz >= 4 * n - 3 && bz <= 4 * n, "R3 busy length (cycles)", bz, 4 * n);
        check(rdy_bad == 0, "R4 ready low while busy", rdy_bad, 0);
        check(start_clk == p, "R8 clock rest in start bit", start_clk, p);
        if (e) check(sclk_bad == 0, "R9 clock phase per bit", sclk_bad, 0);
        else   check(sclk_bad == 0, "R7 clock disabled holds", sclk_bad, 0);
        if (brk_mid) check(bz <= 4 * n, "R6 break while busy ignored", bz, 4 * n);
    endtask

    task automatic run_break(input bit lin, input bit with_valid);
        int bz = 0;
        int low = 0;
        logic rdy;
        wait_idle();
        @(negedge clk);
        lin_en = lin; brk = 1'b1; valid = with_valid; data = 8'hA5;
        #1;
        rdy = ready;
        @(negedge clk);
        brk = 1'b0; valid = 1'b0;
        if (lin) begin
            while (busy) begin
                if (!txd) low++;
                bz++;
                @(negedge clk);
            end
            check(low >= 829 && low <= 832, "R5 break low length (cycles)", low, 832);
            check(bz >= 893 && bz <= 896, "R5 break busy length (cycles)", bz, 896);
            if (with_valid) begin
                check(rdy == 1'b0, "R10 ready low with break", rdy, 0);
                for (int i = 0; i < 12; i++) begin
                    if (busy) bz++;
                    @(negedge clk);
                end
                check(bz <= 896, "R10 byte not taken", bz, 896);
            end
        end else begin
            for (int i = 0; i < 24; i++) begin
                if (busy || !txd) low++;
                @(negedge clk);
            end
            check(low == 0, "R6 break ignored when mode off", low, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        pol = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(txd == 1'b1, "R1 idle line", txd, 1);
        check(busy == 1'b0, "R1 idle busy", busy, 0);
        check(ready == 1'b1, "R1 idle ready", ready, 1);
        check(sclk == 1'b1, "R1 clock rest", sclk, 1);

        // Directed corners.
        run_frame(8'h00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
        run_frame(8'hFF, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0);
        run_frame(8'h81, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
        run_frame(8'h5A, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1);
        run_break(1'b1, 1'b0);
        run_break(1'b0, 1'b0);
        run_break(1'b1, 1'b1);
        run_frame(8'h3C, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);

        // Random frames.
        for (int i = 0; i < 36; i++) begin
            logic [7:0] rd = 8'($urandom);
            logic [1:0] rs = 2'($urandom);
            logic [2:0] rc = 3'($urandom);
            run_frame(rd, rs, rc[0], rc[1], rc[2], ($urandom % 5) == 0);
            if (($urandom % 8) == 0) run_break(1'b1, 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule